// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a page table with two levels that is held in memory. The virtual address is split into three fields, from the top down: a 10-bit directory index, a 10-bit leaf index and a 12-bit page offset. The walker first reads a directory entry at the table base plus four times the directory index. That entry names the physical page that holds a leaf table. The walker then reads the leaf entry at that page plus four times the leaf index. The response joins the leaf entry's page number with the untouched page offset.

Each entry carries a present flag, a write-permission flag, an execute-permission flag and a 20-bit physical page number. Both levels are checked against the kind of access requested. A missing entry at either level ends the walk with a page fault. A missing permission ends it with a protection fault. A walk that stops at the directory level never reads a leaf entry. Requesters hand in one request at a time and get exactly one single-cycle response for it. Toward memory the walker keeps at most one read in flight.

Top module: `pgwalk_top`

## Requirements
- R1: `req_ready` is high only while the walker is idle. A request is taken when `req_valid` and `req_ready` are both high. `req_valid` has no effect while a walk is in progress.
- R2: In the cycle after a request is taken, `mem_rd_en` pulses for one cycle with `mem_rd_addr` = `table_base` + 4 × vaddr[31:22].
- R3: A directory entry whose present flag (bit 0) is 0 gives response code 1 (page fault), and no second memory read is made.
- R4: A present directory entry that lacks the needed permission gives code 2 (protection fault), and no second read is made. A store needs bit 1 (write). A fetch needs bit 2 (execute).
- R5: For a permitted directory entry, the second read address is {entry[31:12], 12'b0} + 4 × vaddr[21:12].
- R6: A leaf entry whose present flag (bit 0) is 0 gives code 1 (page fault).
- R7: A present leaf entry gives code 2 when a store (`req_kind` 1) meets bit 1 = 0, or when a fetch (`req_kind` 2) meets bit 2 = 0. A load (`req_kind` 0 or 3) needs only the present flag.
- R8: Code 0 (OK) returns `rsp_paddr` = {leaf entry[31:12], vaddr[11:0]}. Every fault returns `rsp_paddr` = 0.
- R9: Each request gets exactly one response, with `rsp_valid` high for a single cycle. Code 3 is never produced. No new memory read starts while one is outstanding. Memory returns its data at least one cycle after the read strobe.
- R10: After reset the walker is idle: `req_ready` = 1, `rsp_valid` = 0 and `mem_rd_en` = 0.
- R11: `mem_rd_valid` has no effect while no read is outstanding. The response is produced in the cycle after the data that decides it arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| table_base | input | 32 | Physical byte address of the directory table |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 load |
| rsp_valid | output | 1 | Single-cycle response strobe |
| rsp_code | output | 2 | 0 OK, 1 page fault, 2 protection fault |
| rsp_paddr | output | 32 | Physical address on OK, otherwise 0 |
| mem_rd_en | output | 1 | Single-cycle memory read strobe |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Page table entry read from memory |

## Verification
A wrong walk state shows at the memory port first. An extra, missing or misaddressed read appears one cycle after the request is taken or after the directory data arrives. It is caught before any response. A wrong permission decision or page-number join shows one cycle after the leaf data arrives, as a wrong code or address in the response. A stuck or lost state shows as a missing response, or as `req_ready` high during a walk or low while idle.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    RSP_OK         = 2'd0,
    RSP_PAGE_FAULT = 2'd1,
    RSP_PROT_FAULT = 2'd2
  } rsp_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LVL1 = 2'd1,
    ST_LVL2 = 2'd2
  } st_e;

  localparam int unsigned PTE_PRESENT = 0;
  localparam int unsigned PTE_WRITE   = 1;
  localparam int unsigned PTE_EXEC    = 2;
endpackage

// File: rtl/pgwalk_pte_chk.sv
module pgwalk_pte_chk
  import pgwalk_pkg::*;
#(
  parameter int PTE_W = 32,
  parameter int PPN_W = 20
) (
  input  logic [PTE_W-1:0] pte,
  input  logic [1:0]       kind,
  output logic [1:0]       verdict,
  output logic [PPN_W-1:0] ppn
);
  localparam int RSV_HI = PTE_W - PPN_W - 1;

  logic unused_rsv;
  assign unused_rsv = ^pte[RSV_HI:PTE_EXEC+1];

  assign ppn = pte[PTE_W-1 -: PPN_W];

  always_comb begin
    if (!pte[PTE_PRESENT]) begin
      verdict = RSP_PAGE_FAULT;
    end else begin
      verdict = RSP_OK;
      case (kind)
        ACC_STORE: if (!pte[PTE_WRITE]) verdict = RSP_PROT_FAULT;
        ACC_FETCH: if (!pte[PTE_EXEC])  verdict = RSP_PROT_FAULT;
        default:   verdict = RSP_OK;
      endcase
    end
  end
endmodule

// File: rtl/pgwalk_addr_gen.sv
module pgwalk_addr_gen #(
  parameter int IDX_W    = 10,
  parameter int OFF_W    = 12,
  parameter int PPN_W    = 20,
  parameter int ENTRY_LG = 2,
  localparam int PA_W    = PPN_W + OFF_W
) (
  input  logic [PA_W-1:0]  base,
  input  logic [IDX_W-1:0] dir_idx,
  input  logic [IDX_W-1:0] leaf_idx,
  input  logic [PPN_W-1:0] dir_ppn,
  output logic [PA_W-1:0]  dir_addr,
  output logic [PA_W-1:0]  leaf_addr
);
  localparam int SCALED_W = IDX_W + ENTRY_LG;

  logic [SCALED_W-1:0] dir_scaled;
  logic [SCALED_W-1:0] leaf_scaled;

  assign dir_scaled  = {dir_idx,  {ENTRY_LG{1'b0}}};
  assign leaf_scaled = {leaf_idx, {ENTRY_LG{1'b0}}};

  assign dir_addr  = base + PA_W'(dir_scaled);
  assign leaf_addr = {dir_ppn, {OFF_W{1'b0}}} + PA_W'(leaf_scaled);
endmodule

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
#(
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12,
  parameter int PPN_W  = 20,
  localparam int LO_W  = IDX_W + OFF_W,
  localparam int PA_W  = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [LO_W-1:0]  req_lo,
  input  logic [1:0]       req_kind,
  output logic             req_ready,
  output logic [IDX_W-1:0] held_idx,
  output logic [1:0]       held_kind,
  input  logic [PA_W-1:0]  dir_addr,
  input  logic [PA_W-1:0]  leaf_addr,
  input  logic [1:0]       verdict,
  input  logic [PPN_W-1:0] ppn,
  input  logic             mem_rd_valid,
  output logic             mem_rd_en,
  output logic [PA_W-1:0]  mem_rd_addr,
  output logic             rsp_valid,
  output logic [1:0]       rsp_code,
  output logic [PA_W-1:0]  rsp_paddr
);
  st_e              state_q, state_d;
  logic [LO_W-1:0]  lo_q;
  logic [1:0]       kind_q;
  logic             rd_en_q;
  logic [PA_W-1:0]  rd_addr_q;
  logic             rsp_valid_q;
  logic [1:0]       rsp_code_q;
  logic [PA_W-1:0]  rsp_paddr_q;

  logic             accept, dir_done, leaf_done, issue, finish, pass;
  logic [PA_W-1:0]  issue_addr, fin_paddr;

  assign pass      = (verdict == RSP_OK);
  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign dir_done  = (state_q == ST_LVL1) && mem_rd_valid;
  assign leaf_done = (state_q == ST_LVL2) && mem_rd_valid;
  assign issue     = accept || (dir_done && pass);
  assign finish    = (dir_done && !pass) || leaf_done;
  assign issue_addr = accept ? dir_addr : leaf_addr;
  assign fin_paddr  = (leaf_done && pass) ? {ppn, lo_q[OFF_W-1:0]} : '0;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (accept) state_d = ST_LVL1;
      ST_LVL1: if (dir_done) state_d = pass ? ST_LVL2 : ST_IDLE;
      ST_LVL2: if (leaf_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      rd_en_q     <= 1'b0;
      rsp_valid_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      rd_en_q     <= issue;
      rsp_valid_q <= finish;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      kind_q <= '0;
    end else if (accept) begin
      lo_q   <= req_lo;
      kind_q <= req_kind;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr_q <= '0;
    end else if (issue) begin
      rd_addr_q <= issue_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_code_q  <= '0;
      rsp_paddr_q <= '0;
    end else if (finish) begin
      rsp_code_q  <= verdict;
      rsp_paddr_q <= fin_paddr;
    end
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign held_idx    = lo_q[LO_W-1 -: IDX_W];
  assign held_kind   = kind_q;
  assign mem_rd_en   = rd_en_q;
  assign mem_rd_addr = rd_addr_q;
  assign rsp_valid   = rsp_valid_q;
  assign rsp_code    = rsp_code_q;
  assign rsp_paddr   = rsp_paddr_q;
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top #(
  parameter int IDX_W    = 10,
  parameter int OFF_W    = 12,
  parameter int PPN_W    = 20,
  parameter int PTE_W    = 32,
  parameter int ENTRY_LG = 2,
  localparam int VA_W    = 2 * IDX_W + OFF_W,
  localparam int PA_W    = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PA_W-1:0]  table_base,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_kind,
  output logic             rsp_valid,
  output logic [1:0]       rsp_code,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             mem_rd_en,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic             mem_rd_valid,
  input  logic [PTE_W-1:0] mem_rd_data
);
  localparam int LO_W = IDX_W + OFF_W;

  logic [IDX_W-1:0] held_idx;
  logic [1:0]       held_kind;
  logic [PA_W-1:0]  dir_addr, leaf_addr;
  logic [1:0]       verdict;
  logic [PPN_W-1:0] ppn;

  pgwalk_addr_gen #(
    .IDX_W(IDX_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .ENTRY_LG(ENTRY_LG)
  ) u_addr (
    .base      (table_base),
    .dir_idx   (req_vaddr[VA_W-1 -: IDX_W]),
    .leaf_idx  (held_idx),
    .dir_ppn   (ppn),
    .dir_addr  (dir_addr),
    .leaf_addr (leaf_addr)
  );

  pgwalk_pte_chk #(.PTE_W(PTE_W), .PPN_W(PPN_W)) u_chk_pte (
    .pte     (mem_rd_data),
    .kind    (held_kind),
    .verdict (verdict),
    .ppn     (ppn)
  );

  pgwalk_ctrl #(.IDX_W(IDX_W), .OFF_W(OFF_W), .PPN_W(PPN_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_lo       (req_vaddr[LO_W-1:0]),
    .req_kind     (req_kind),
    .req_ready    (req_ready),
    .held_idx     (held_idx),
    .held_kind    (held_kind),
    .dir_addr     (dir_addr),
    .leaf_addr    (leaf_addr),
    .verdict      (verdict),
    .ppn          (ppn),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_en    (mem_rd_en),
    .mem_rd_addr  (mem_rd_addr),
    .rsp_valid    (rsp_valid),
    .rsp_code     (rsp_code),
    .rsp_paddr    (rsp_paddr)
  );
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic [1:0]      rsp_code,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            mem_rd_en,
  input logic            mem_rd_valid
);
  logic busy_q, outst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      outst_q <= 1'b0;
    end else begin
      busy_q  <= (req_valid && req_ready) || (busy_q && !rsp_valid);
      outst_q <= mem_rd_en || (outst_q && !mem_rd_valid);
    end
  end

  a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !rsp_valid) |-> !req_ready);

  a_r2_read_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> mem_rd_en);

  a_r8_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code != 2'd0) |-> (rsp_paddr == '0));

  a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !outst_q);

  a_r9_rsp_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r9_rsp_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> busy_q);

  a_r9_read_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> busy_q);

  a_r9_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_code != 2'd3));

  a_r11_rsp_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(mem_rd_valid));
endmodule

bind pgwalk_top pgwalk_chk #(.PA_W(PA_W)) u_pgwalk_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .rsp_code     (rsp_code),
  .rsp_paddr    (rsp_paddr),
  .mem_rd_en    (mem_rd_en),
  .mem_rd_valid (mem_rd_valid)
);

// File: tb/test_pgwalk_top.sv
module test_pgwalk_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] table_base = 32'h0010_0000;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_code;
  logic [31:0] rsp_paddr;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;

  always #10 clk = ~clk;

  pgwalk_top i_pgwalk_top (
    .clk(clk), .rst_n(rst_n), .table_base(table_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .rsp_paddr(rsp_paddr), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;
  int lat_cfg = 1;
  bit stray_req = 0;

  logic [31:0] mem_m [logic [31:0]];
  logic [1:0]  exp_code_q [$];
  logic [31:0] exp_pa_q [$];
  string       exp_tag_q [$];
  logic [31:0] exp_ra_q [$];
  string       exp_rtag_q [$];

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem_m.exists(a) ? mem_m[a] : 32'h0;
  endfunction

  function automatic logic [31:0] mk_pte(input logic [19:0] p, input bit v, input bit w, input bit x);
    return {p, 9'b0, x, w, v};
  endfunction

  function automatic logic [31:0] mk_va(input int i1, input int i2, input int off);
    return {i1[9:0], i2[9:0], off[11:0]};
  endfunction

  function automatic bit rights_ok(input logic [31:0] pte, input logic [1:0] kind);
    if (kind == 2'd1) return pte[1];
    if (kind == 2'd2) return pte[2];
    return 1'b1;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Driver: computes expectations from the requirement text, pushes them, drives one request
  task automatic walk(input logic [31:0] va, input logic [1:0] kind, input bit noise);
    logic [31:0] a1, e1, a2, e2;
    a1 = table_base + {20'b0, va[31:22], 2'b00};
    e1 = rd(a1);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_vaddr = va; req_kind = kind; req_valid = 1'b1;
    exp_ra_q.push_back(a1); exp_rtag_q.push_back("R2");
    if (!e1[0]) begin
      exp_code_q.push_back(2'd1); exp_pa_q.push_back(32'h0); exp_tag_q.push_back("R3");
    end else if (!rights_ok(e1, kind)) begin
      exp_code_q.push_back(2'd2); exp_pa_q.push_back(32'h0); exp_tag_q.push_back("R4");
    end else begin
      a2 = {e1[31:12], 12'h0} + {20'b0, va[21:12], 2'b00};
      e2 = rd(a2);
      exp_ra_q.push_back(a2); exp_rtag_q.push_back("R5");
      if (!e2[0]) begin
        exp_code_q.push_back(2'd1); exp_pa_q.push_back(32'h0); exp_tag_q.push_back("R6");
      end else if (!rights_ok(e2, kind)) begin
        exp_code_q.push_back(2'd2); exp_pa_q.push_back(32'h0); exp_tag_q.push_back("R7");
      end else begin
        exp_code_q.push_back(2'd0); exp_pa_q.push_back({e2[31:12], va[11:0]}); exp_tag_q.push_back("R8");
      end
    end
    @(negedge clk);
    if (noise) begin
      // R1: request strobe during a walk must be ignored
      for (int k = 0; k < 2; k++) begin
        req_vaddr = mk_va(2, 0, 0); req_kind = 2'd0; req_valid = 1'b1;
        check(req_ready == 1'b0, "R1", "ready during walk", {31'b0, req_ready}, 32'h0);
        @(negedge clk);
      end
    end
    req_valid = 1'b0;
  endtask

  // Monitor: pops the scoreboard on every response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_code_q.size() == 0) begin
        check(1'b0, "R9", "response with none expected", {30'b0, rsp_code}, 32'h0);
      end else begin
        logic [1:0] ec; logic [31:0] ep; string et;
        ec = exp_code_q.pop_front(); ep = exp_pa_q.pop_front(); et = exp_tag_q.pop_front();
        check(rsp_code == ec, et, "response code", {30'b0, rsp_code}, {30'b0, ec});
        check(rsp_paddr == ep, et, "response paddr", rsp_paddr, ep);
      end
    end
  end

  // Memory model with configurable latency, also checks read addresses
  bit          pend = 0;
  int          cnt = 0;
  logic [31:0] pdata = '0;
  always @(negedge clk) begin
    mem_rd_valid = 1'b0;
    if (pend && cnt <= 1) begin
      mem_rd_valid = 1'b1; mem_rd_data = pdata; pend = 0;
    end else if (pend) begin
      cnt--;
    end else if (stray_req) begin
      mem_rd_valid = 1'b1; mem_rd_data = mk_pte(20'h00ABC, 1, 1, 1); stray_req = 0;
    end
    if (rst_n && mem_rd_en) begin
      if (exp_ra_q.size() == 0) begin
        check(1'b0, "R3", "unexpected memory read", mem_rd_addr, 32'h0);
      end else begin
        logic [31:0] ea; string et;
        ea = exp_ra_q.pop_front(); et = exp_rtag_q.pop_front();
        check(mem_rd_addr == ea, et, "read address", mem_rd_addr, ea);
      end
      pdata = rd(mem_rd_addr); pend = 1; cnt = lat_cfg;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // directory entries
    mem_m[32'h0010_0004] = mk_pte(20'h00200, 1, 1, 1);
    mem_m[32'h0010_0008] = mk_pte(20'h00400, 0, 1, 1);
    mem_m[32'h0010_000C] = mk_pte(20'h00300, 1, 0, 0);
    // leaf table under directory slot 1
    mem_m[32'h0020_0000] = mk_pte(20'h12345, 1, 1, 1);
    mem_m[32'h0020_0014] = mk_pte(20'h0ABCD, 1, 0, 0);
    mem_m[32'h0020_001C] = mk_pte(20'h00777, 1, 0, 1);
    mem_m[32'h0020_0024] = mk_pte(20'h99999, 0, 1, 1);
    mem_m[32'h0020_0FFC] = mk_pte(20'hFFFFF, 1, 1, 0);
    // leaf tables under slots 3 and the absent slot 2
    mem_m[32'h0030_0000] = mk_pte(20'h55555, 1, 1, 1);
    mem_m[32'h0040_0000] = mk_pte(20'h66666, 1, 1, 1);

    repeat (3) @(negedge clk);
    // R10: reset state
    check(req_ready == 1'b1, "R10", "ready in reset", {31'b0, req_ready}, 32'h1);
    check(rsp_valid == 1'b0, "R10", "rsp_valid in reset", {31'b0, rsp_valid}, 32'h0);
    check(mem_rd_en == 1'b0, "R10", "mem_rd_en in reset", {31'b0, mem_rd_en}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R10", "ready after reset", {31'b0, req_ready}, 32'h1);

    lat_cfg = 1;
    walk(mk_va(1, 0, 12'hABC), 2'd0, 0);   // R8 load OK
    walk(mk_va(1, 0, 12'h001), 2'd1, 0);   // R8 store OK
    walk(mk_va(1, 7, 12'h010), 2'd2, 0);   // R7 fetch from execute page OK
    walk(mk_va(1, 7, 12'h010), 2'd1, 0);   // R7 store to non-writable
    lat_cfg = 2;
    walk(mk_va(1, 5, 12'h123), 2'd0, 0);   // R7 load of read-only page OK
    walk(mk_va(1, 5, 12'h123), 2'd3, 0);   // R7 kind 3 acts as load
    walk(mk_va(1, 5, 12'h123), 2'd1, 0);   // R7 store fault
    walk(mk_va(1, 5, 12'h123), 2'd2, 0);   // R7 fetch fault
    walk(mk_va(1, 9, 12'h000), 2'd0, 0);   // R6 leaf absent
    lat_cfg = 3;
    walk(mk_va(2, 0, 12'h000), 2'd0, 0);   // R3 directory absent, no second read
    walk(mk_va(0, 0, 12'h000), 2'd0, 0);   // R3 lowest slot empty
    walk(mk_va(1023, 1023, 12'hFFF), 2'd0, 0); // R3 highest slot empty
    walk(mk_va(3, 0, 12'h456), 2'd1, 0);   // R4 directory denies store
    walk(mk_va(3, 0, 12'h456), 2'd2, 0);   // R4 directory denies fetch
    walk(mk_va(3, 0, 12'h456), 2'd0, 0);   // R5 load passes directory
    walk(mk_va(1, 1023, 12'hFFF), 2'd0, 0); // R5 top leaf slot, R8 all-ones address
    walk(mk_va(1, 0, 12'h777), 2'd0, 1);   // R1 strobe during walk ignored

    // R11: stray read data while idle
    @(negedge clk);
    while (!req_ready || exp_code_q.size() != 0) @(negedge clk);
    stray_req = 1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(rsp_valid == 1'b0, "R11", "rsp after stray data", {31'b0, rsp_valid}, 32'h0);
      check(mem_rd_en == 1'b0, "R11", "read after stray data", {31'b0, mem_rd_en}, 32'h0);
      check(req_ready == 1'b1, "R11", "ready after stray data", {31'b0, req_ready}, 32'h1);
    end
    lat_cfg = 1;
    walk(mk_va(1, 0, 12'h020), 2'd2, 0);   // R11 walk still correct afterwards

    @(negedge clk);
    while (exp_code_q.size() != 0 || !req_ready) @(negedge clk);
    repeat (3) @(negedge clk);
    check(exp_code_q.size() == 0, "R9", "responses outstanding", exp_code_q.size(), 32'h0);
    check(exp_ra_q.size() == 0, "R5", "reads never issued", exp_ra_q.size(), 32'h0);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule